// File: doc/BRIEF.md
# Single-Instance Countdown Timer with Early Warning

This block replaces a long timing constraint in a control path with one counter, so the controller around it can stay small and free of time bookkeeping. The controller issues a start command together with a duration of N clock cycles. The timer counts one cycle per clock and raises a one-cycle expiry pulse N cycles after the start. It also raises a one-cycle warning pulse exactly one cycle before expiry, so the controller can prepare its reaction and apply it in the expiry cycle.

Each constraint gets exactly one timer instance. A busy output tells the controller that the timer is in use, and the controller must not start it again while busy is high. The timer does not queue or restart on such a command. It ignores the command and sets a sticky error flag. A zero duration has no meaning here, so it is rejected and sets a second sticky flag. Only the synchronous reset clears these flags.

Top module: `span_timer`

## Requirements
- R1: For a duration N of 2 or more, `warn_o` is high for exactly one cycle, in the cycle just before `done_o` is high.
- R2: `done_o` is never high unless `warn_o` was high in the previous cycle.
- R3: If a start with duration N is accepted in cycle 0, `done_o` is high in cycle N and only in that cycle.
- R4: `busy_o` is high from cycle 1 through cycle N and low in cycle N+1. A start presented in cycle N+1 is accepted.
- R5: A start presented while `busy_o` is high is ignored, and the running count keeps its timing. From the next cycle on, `err_busy_o` is high and stays high until reset.
- R6: For a duration of 1, `warn_o` is high in the start cycle itself, and `done_o` is high in the following cycle.
- R7: A start with duration 0 while idle is rejected. `busy_o` stays low, and from the next cycle on `err_zero_o` is high and stays high until reset.
- R8: While `rst` is high at a clock edge, the count, `busy_o`, `warn_o`, `done_o` and both error flags are cleared at that edge. A start presented during reset is not accepted.
- R9: A start with duration 0 presented while busy counts as a busy violation only. It sets `err_busy_o` and leaves `err_zero_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start command, sampled at the rising edge |
| dur_i | input | CNT_W | Duration in clock cycles, used when start_i is high |
| busy_o | output | 1 | Timer in use (cycle after start through expiry cycle) |
| warn_o | output | 1 | Warning pulse, one cycle before expiry |
| done_o | output | 1 | Expiry pulse |
| err_busy_o | output | 1 | Sticky flag: start seen while busy |
| err_zero_o | output | 1 | Sticky flag: start with zero duration while idle |

## Verification
Two events can land in the same cycle: the expiry pulse and a new start command. In the expiry cycle `busy_o` is still high, so the start must be rejected and flagged, and the start one cycle later must be accepted. The bench provokes this with directed starts placed exactly on the `done_o` cycle and on the cycle after it, and random traffic repeats it with short durations. A cycle-stepped model built from the requirements judges each cycle: it checks that the busy flag changes and the pulse timing of the running count does not. The duration-1 case also puts the warning and the start in one cycle, and the bench checks it separately.

// File: rtl/span_timer_pkg.sv
`timescale 1ns/1ps
package span_timer_pkg;
  // Classification of a start command in the current cycle
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_TAKE = 2'd1,
    CMD_BUSY = 2'd2,
    CMD_ZERO = 2'd3
  } cmd_e;
endpackage

// File: rtl/span_timer_gate.sv
`timescale 1ns/1ps
module span_timer_gate
  import span_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             busy,
  output cmd_e             cmd,
  output logic             take,
  output logic             take_one
);
  localparam logic [CNT_W-1:0] DUR_ZERO = '0;
  localparam logic [CNT_W-1:0] DUR_ONE  = CNT_W'(1);

  always_comb begin
    if (rst || !start_i)      cmd = CMD_NONE;
    else if (busy)            cmd = CMD_BUSY;  // busy outranks zero duration
    else if (dur_i == DUR_ZERO) cmd = CMD_ZERO;
    else                      cmd = CMD_TAKE;
  end

  assign take     = (cmd == CMD_TAKE);
  assign take_one = take && (dur_i == DUR_ONE);
endmodule

// File: rtl/span_timer_count.sv
`timescale 1ns/1ps
module span_timer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy,
  output logic             warn_q,
  output logic             done_q
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] rem_q;   // cycles left until the expiry cycle

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= ZERO;
      busy   <= 1'b0;
      warn_q <= 1'b0;
      done_q <= 1'b0;
    end else if (take) begin
      rem_q  <= dur_i - ONE;
      busy   <= 1'b1;
      warn_q <= (dur_i == TWO);
      done_q <= (dur_i == ONE);
    end else begin
      if (busy && rem_q != ZERO) rem_q <= rem_q - ONE;
      busy   <= busy && !done_q;
      warn_q <= busy && (rem_q == TWO);
      done_q <= busy && (rem_q == ONE);
    end
  end
endmodule

// File: rtl/span_timer_flags.sv
`timescale 1ns/1ps
module span_timer_flags
  import span_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  output logic err_busy,
  output logic err_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_busy <= 1'b0;
      err_zero <= 1'b0;
    end else begin
      if (cmd == CMD_BUSY) err_busy <= 1'b1;
      if (cmd == CMD_ZERO) err_zero <= 1'b1;
    end
  end
endmodule

// File: rtl/span_timer.sv
`timescale 1ns/1ps
module span_timer
  import span_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             warn_o,
  output logic             done_o,
  output logic             err_busy_o,
  output logic             err_zero_o
);
  cmd_e cmd;
  logic take, take_one, busy, warn_q, done_q;

  span_timer_gate #(.CNT_W(CNT_W)) u_gate (
    .rst(rst), .start_i(start_i), .dur_i(dur_i), .busy(busy),
    .cmd(cmd), .take(take), .take_one(take_one)
  );

  span_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .take(take), .dur_i(dur_i),
    .busy(busy), .warn_q(warn_q), .done_q(done_q)
  );

  span_timer_flags u_flags (
    .clk(clk), .rst(rst), .cmd(cmd),
    .err_busy(err_busy_o), .err_zero(err_zero_o)
  );

  assign busy_o = busy;
  assign done_o = done_q;
  // a one-cycle duration warns in its own start cycle
  assign warn_o = warn_q | take_one;
endmodule

// File: rtl/span_timer_chk.sv
`timescale 1ns/1ps
module span_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [CNT_W-1:0] dur_i,
  input logic             busy_o,
  input logic             warn_o,
  input logic             done_o,
  input logic             err_busy_o,
  input logic             err_zero_o
);
  p_warn_then_done_r1: assert property (@(posedge clk) disable iff (rst)
    warn_o |=> done_o);

  p_done_needs_warn_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(warn_o));

  p_busy_on_take_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && dur_i != '0) |=> busy_o);

  p_busy_drops_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

  p_ignore_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && !done_o) |=> busy_o);

  p_flag_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> err_busy_o);

  p_sticky_busy_r5: assert property (@(posedge clk) disable iff (rst)
    err_busy_o |=> err_busy_o);

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && dur_i == CNT_W'(1)) |-> warn_o);

  p_zero_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && dur_i == '0) |=> (err_zero_o && !busy_o));

  p_sticky_zero_r7: assert property (@(posedge clk) disable iff (rst)
    err_zero_o |=> err_zero_o);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !err_busy_o && !err_zero_o));

  p_busy_zero_only_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && dur_i == '0 && !err_zero_o) |=> !err_zero_o);
endmodule

bind span_timer span_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .dur_i(dur_i),
  .busy_o(busy_o), .warn_o(warn_o), .done_o(done_o),
  .err_busy_o(err_busy_o), .err_zero_o(err_zero_o)
);

// File: tb/span_timer_tb.sv
`timescale 1ns/1ps
module span_timer_tb;
  localparam int CNT_W = 16;
  localparam real PERIOD = 8.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] dur_i = '0;
  logic busy_o, warn_o, done_o, err_busy_o, err_zero_o;

  int checks = 0;
  int fails  = 0;

  // reference state, derived from the requirements
  logic m_busy = 1'b0;
  int   m_left = 0;
  logic m_eb = 1'b0, m_ez = 1'b0;
  logic last_warn = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  span_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dur_i(dur_i),
    .busy_o(busy_o), .warn_o(warn_o), .done_o(done_o),
    .err_busy_o(err_busy_o), .err_zero_o(err_zero_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_warn(input logic acc, input int d);
    return (m_busy && m_left == 1) || (acc && d == 1);
  endfunction

  // one clock cycle: drive, sample mid-cycle, advance the model
  task automatic step(input logic s, input int d);
    logic acc;
    @(posedge clk); #2;
    start_i = s; dur_i = CNT_W'(d);
    #2;
    acc = s && !m_busy && d != 0;
    chk("R4 busy", busy_o, m_busy);
    chk("R3 done", done_o, m_busy && m_left == 0);
    if (acc && d == 1) chk("R6 warn in start cycle", warn_o, 1'b1);
    else               chk("R1 warn", warn_o, exp_warn(acc, d));
    chk("R5 err_busy", err_busy_o, m_eb);
    chk("R7 err_zero", err_zero_o, m_ez);
    if (done_o) chk("R2 done after warn", last_warn, 1'b1);
    last_warn = warn_o;
    if (s && m_busy) m_eb = 1'b1;
    if (s && !m_busy && d == 0) m_ez = 1'b1;
    if (acc) begin
      m_busy = 1'b1; m_left = d - 1;
    end else if (m_busy) begin
      if (m_left == 0) m_busy = 1'b0; else m_left--;
    end
  endtask

  task automatic do_reset(input logic with_start);
    @(posedge clk); #2;
    rst = 1'b1; start_i = with_start; dur_i = CNT_W'(3);
    repeat (2) @(posedge clk);
    #2 rst = 1'b0; start_i = 1'b0;
    m_busy = 1'b0; m_left = 0; m_eb = 1'b0; m_ez = 1'b0; last_warn = 1'b0;
    #2;
    chk("R8 busy after reset", busy_o, 1'b0);
    chk("R8 done after reset", done_o, 1'b0);
    chk("R8 warn after reset", warn_o, 1'b0);
    chk("R8 err_busy after reset", err_busy_o, 1'b0);
    chk("R8 err_zero after reset", err_zero_o, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b1);
    // R6: one-cycle duration
    step(1'b1, 1); idle(3);
    // R1, R3: short and longer durations
    step(1'b1, 2); idle(4);
    step(1'b1, 5); idle(7);
    // R7: zero duration while idle
    step(1'b1, 0); idle(2);
    chk("R7 timer idle after zero start", busy_o, 1'b0);
    do_reset(1'b0);
    // R5: restart mid-count and exactly in the done cycle, then R4 restart next cycle
    step(1'b1, 4); step(1'b0, 0); step(1'b1, 9);
    step(1'b0, 0); step(1'b1, 3);      // cycle 4 is the done cycle
    step(1'b1, 2);                     // cycle 5: accepted
    idle(4);
    // R9: zero duration while busy flags busy only
    do_reset(1'b0);
    step(1'b1, 6); step(1'b1, 0); idle(8);
    chk("R9 err_zero untouched", err_zero_o, 1'b0);
    chk("R9 err_busy set", err_busy_o, 1'b1);
    // long duration
    step(1'b1, 300); idle(305);
    // R8: reset in the middle of a count
    step(1'b1, 40); idle(10);
    do_reset(1'b1);
    idle(45);
    chk("R8 no late expiry", done_o, 1'b0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic s = ($urandom % 3) == 0;
      int   d = (($urandom % 8) == 0) ? int'($urandom % 60) : int'($urandom % 8);
      step(s, d);
      if (($urandom % 1500) == 0) do_reset(1'b1);
    end
    idle(70);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule